// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End

This block is the bus-facing half of a two-wire (I2C) slave. It oversamples the SCL and SDA lines with the system clock, detects START, repeated START and STOP, shifts address and data bytes in, and pulls SDA low through an open-drain enable for acknowledges and read data. It never drives SCL. Behind it sits a register engine. The engine receives each written byte with its position in the transfer, is told when a transfer starts or stops, and supplies the byte to send whenever a read byte is due.

The device address is seven bits. The upper six bits are fixed at `111010` and the lowest bit is taken from a strap pin, so the slave answers at 0x74 or 0x75. Two special address bytes are also decoded. The general-call address 0x00 leads to a one-cycle reset pulse when the data byte 0x06 follows it. The high-speed master code `00001xxx` is never acknowledged, but it raises a mode flag that stays set until the next STOP.

Top module: `i2c_slave_front`

## Requirements
- R1: An address byte whose upper seven bits equal `111010` followed by the strap pin level is acknowledged. Bit 0 of that byte selects the direction of the transfer: 0 for write, 1 for read.
- R2: `startEvt` pulses for one cycle when SDA falls while SCL is high. `stopEvt` pulses for one cycle when SDA rises while SCL is high. Every START, including a repeated START, restarts address reception.
- R3: The slave pulls SDA low during the ninth clock of every byte it acknowledges. `sdaOe` changes only while the synchronized SCL is low.
- R4: In a write transfer, each data byte is acknowledged and presented on `rxByte` with a one-cycle `rxValid`. `byteIdx` starts at 0 after each START, goes up by one per byte, and holds at its maximum value.
- R5: In a read transfer, one `txReq` pulse samples `txByte` per byte, using the `byteIdx` value present at that moment. The byte is shifted out MSB first. A master NACK ends the transfer, SDA is released, and no further byte is requested.
- R6: After an address byte that matches nothing, the slave acknowledges nothing, delivers no byte and leaves SDA released until the next START or STOP.
- R7: An address byte of the form `00001xxx` is not acknowledged, whatever the three low bits are, and it sets `hsMode`.
- R8: `hsMode` stays set across repeated STARTs and clears at the first STOP.
- R9: The general-call address byte 0x00 is always acknowledged. A following data byte 0x06 is acknowledged and produces a one-cycle `gcReset` pulse. Any other general-call data byte is not acknowledged and produces no pulse.
- R10: While reset is asserted, `sdaOe` is 0, `hsMode` is 0 and `byteIdx` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| strapLsb | input | 1 | Strap pin giving the lowest address bit |
| sdaOe | output | 1 | 1 pulls SDA low (open drain) |
| startEvt | output | 1 | One-cycle pulse on START or repeated START |
| stopEvt | output | 1 | One-cycle pulse on STOP |
| rxValid | output | 1 | One-cycle pulse marking a written data byte |
| rxByte | output | 8 | Written data byte, valid with rxValid |
| txReq | output | 1 | Pulse in the cycle txByte is sampled |
| txByte | input | 8 | Read byte supplied by the register engine |
| byteIdx | output | IDX_W | Position of the current data byte in the transfer |
| hsMode | output | 1 | High-speed mode flag |
| gcReset | output | 1 | One-cycle pulse after a general-call reset command |

## Verification
The bench builds the block with a two-stage synchronizer and `IDX_W` set to 3, so `byteIdx` saturates at 7. A nine-byte write therefore reaches the hold-at-maximum case of the index. Each quarter of a bus bit lasts ten system clocks. That leaves the synchronizer and edge-detect latency well inside the SCL low phase, so acknowledge and read-data timing are checked against a realistic setup margin. The strap pin is varied at random, so both device addresses, the neighbouring non-matching address and arbitrary foreign addresses all occur in one run.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;

  typedef enum logic [2:0] {
    StIdle,
    StAddr,
    StWrite,
    StRead,
    StGcall,
    StIgnore
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrBits;
    logic clrIdx;
    logic incIdx;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

  localparam logic [3:0] LastDataRise = 4'd7;
  localparam logic [3:0] AckPhase     = 4'd8;
  localparam logic [3:0] ByteEnd      = 4'd9;

endpackage

// File: rtl/i2c_slave_dpath.sv
module i2c_slave_dpath
  import i2c_slave_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  dpStrobe_t        strobe,
  input  logic [7:0]       txByte,
  output logic             sclLvl,
  output logic             sdaLvl,
  output logic             sclRise,
  output logic             sclFall,
  output logic             startDet,
  output logic             stopDet,
  output logic [3:0]       bitCnt,
  output logic [7:0]       rxNext,
  output logic             txNextBit,
  output logic [IDX_W-1:0] byteIdx
);

  localparam logic [IDX_W-1:0] IdxMax = {IDX_W{1'b1}};

  logic [SYNC_STAGES-1:0] sclChain;
  logic [SYNC_STAGES-1:0] sdaChain;
  logic                   sclPrev;
  logic                   sdaPrev;
  logic [7:0]             rxSh;
  logic [7:0]             txSh;

  // synchronizer: depth chosen by parameter, idle bus level on reset
  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclChain <= 1'b1;
          sdaChain <= 1'b1;
        end else begin
          sclChain <= sclIn;
          sdaChain <= sdaIn;
        end
      end
    end else begin : gSyncMany
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= {sclChain[SYNC_STAGES-2:0], sclIn};
          sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclLvl = sclChain[SYNC_STAGES-1];
  assign sdaLvl = sdaChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

  // receive shifter, sampled on SCL rise
  always_ff @(posedge clk) begin
    if (!rstN) rxSh <= '0;
    else if (sclRise) rxSh <= {rxSh[6:0], sdaLvl};
  end
  assign rxNext = {rxSh[6:0], sdaLvl};

  // bit position within the nine-clock byte frame
  always_ff @(posedge clk) begin
    if (!rstN) bitCnt <= '0;
    else if (strobe.clrBits) bitCnt <= '0;
    else if (sclRise && bitCnt != ByteEnd) bitCnt <= bitCnt + 4'd1;
  end

  // transmit shifter, MSB first
  always_ff @(posedge clk) begin
    if (!rstN) txSh <= '0;
    else if (strobe.loadTx) txSh <= txByte;
    else if (strobe.shiftTx) txSh <= {txSh[6:0], 1'b0};
  end
  assign txNextBit = strobe.loadTx ? txByte[7] : txSh[6];

  // saturating byte index
  always_ff @(posedge clk) begin
    if (!rstN) byteIdx <= '0;
    else if (strobe.clrIdx) byteIdx <= '0;
    else if (strobe.incIdx && byteIdx != IdxMax) byteIdx <= byteIdx + 1'b1;
  end

  p_frame_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (bitCnt == 4'd0));

  p_frame_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt == ByteEnd && !strobe.clrBits) |=> (bitCnt == ByteEnd));

  p_idx_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (byteIdx == '0));

endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_slave_pkg::*;
#(
  parameter logic [5:0] DEV_PREFIX = 6'b111010,
  parameter logic [7:0] GC_CMD     = 8'h06,
  parameter logic [4:0] HS_TAG     = 5'b00001
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       strapLsb,
  input  logic       sclLvl,
  input  logic       sdaLvl,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [3:0] bitCnt,
  input  logic [7:0] rxNext,
  input  logic       txNextBit,
  output dpStrobe_t  strobe,
  output logic       sdaOe,
  output logic       rxFire,
  output logic       hsMode,
  output logic       gcReset
);

  busState_e state, stNext;
  logic oeR, oeNext;
  logic ackPend, ackNext;
  logic slvAck, slvNext;
  logic hsR, hsNext;
  logic gcR, gcNext;
  logic byteDone;

  assign byteDone = sclRise && (bitCnt == LastDataRise);

  always_comb begin
    stNext  = state;
    oeNext  = oeR;
    ackNext = ackPend;
    slvNext = slvAck;
    hsNext  = hsR;
    gcNext  = 1'b0;
    rxFire  = 1'b0;
    strobe  = '0;
    if (stopDet) begin
      stNext  = StIdle;
      oeNext  = 1'b0;
      ackNext = 1'b0;
      slvNext = 1'b0;
      hsNext  = 1'b0;
    end else if (startDet) begin
      stNext         = StAddr;
      oeNext         = 1'b0;
      ackNext        = 1'b0;
      slvNext        = 1'b0;
      strobe.clrBits = 1'b1;
      strobe.clrIdx  = 1'b1;
    end else begin
      unique case (state)
        StAddr: begin
          if (byteDone) begin
            if (rxNext[7:1] == {DEV_PREFIX, strapLsb}) begin
              ackNext = 1'b1;
              slvNext = rxNext[0];
              stNext  = rxNext[0] ? StRead : StWrite;
            end else if (rxNext == 8'h00) begin
              ackNext = 1'b1;
              stNext  = StGcall;
            end else begin
              stNext = StIgnore;
              if (rxNext[7:3] == HS_TAG) hsNext = 1'b1;
            end
          end
        end
        StWrite, StGcall: begin
          if (byteDone) begin
            if (state == StWrite) begin
              ackNext       = 1'b1;
              rxFire        = 1'b1;
              strobe.incIdx = 1'b1;
            end else if (rxNext == GC_CMD) begin
              ackNext = 1'b1;
              gcNext  = 1'b1;
            end else begin
              ackNext = 1'b0;
              stNext  = StIgnore;
            end
          end
          if (sclFall && bitCnt == AckPhase) oeNext = ackPend;
          if (sclFall && bitCnt == ByteEnd) begin
            oeNext         = 1'b0;
            ackNext        = 1'b0;
            strobe.clrBits = 1'b1;
          end
        end
        StRead: begin
          if (sclFall) begin
            if (bitCnt == AckPhase) begin
              oeNext = slvAck;
            end else if (bitCnt == ByteEnd) begin
              strobe.clrBits = 1'b1;
              strobe.loadTx  = 1'b1;
              strobe.incIdx  = 1'b1;
              oeNext         = ~txNextBit;
              slvNext        = 1'b0;
              ackNext        = 1'b0;
            end else if (!slvAck && bitCnt != 4'd0) begin
              strobe.shiftTx = 1'b1;
              oeNext         = ~txNextBit;
            end
          end
          if (sclRise && bitCnt == AckPhase && !slvAck && sdaLvl) begin
            stNext = StIgnore;
            oeNext = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= StIdle;
      oeR     <= 1'b0;
      ackPend <= 1'b0;
      slvAck  <= 1'b0;
      hsR     <= 1'b0;
      gcR     <= 1'b0;
    end else begin
      state   <= stNext;
      oeR     <= oeNext;
      ackPend <= ackNext;
      slvAck  <= slvNext;
      hsR     <= hsNext;
      gcR     <= gcNext;
    end
  end

  assign sdaOe   = oeR;
  assign hsMode  = hsR;
  assign gcReset = gcR;

  p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(oeR) |-> !sclLvl);

  p_ack_ninth_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sclRise && bitCnt == AckPhase && ackPend) |-> oeR);

  p_ignore_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == StIgnore) |-> (!oeR && !rxFire));

  p_hs_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !hsR);

  p_hs_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (startDet && hsR) |=> hsR);

endmodule

// File: rtl/i2c_slave_front.sv
module i2c_slave_front
  import i2c_slave_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         IDX_W       = 4,
  parameter logic [5:0] DEV_PREFIX  = 6'b111010,
  parameter logic [7:0] GC_CMD      = 8'h06,
  parameter logic [4:0] HS_TAG      = 5'b00001
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             strapLsb,
  output logic             sdaOe,
  output logic             startEvt,
  output logic             stopEvt,
  output logic             rxValid,
  output logic [7:0]       rxByte,
  output logic             txReq,
  input  logic [7:0]       txByte,
  output logic [IDX_W-1:0] byteIdx,
  output logic             hsMode,
  output logic             gcReset
);

  dpStrobe_t  strobe;
  logic       sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic [3:0] bitCnt;
  logic [7:0] rxNext;
  logic       txNextBit;

  i2c_slave_dpath #(
    .SYNC_STAGES(SYNC_STAGES),
    .IDX_W      (IDX_W)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .strobe   (strobe),
    .txByte   (txByte),
    .sclLvl   (sclLvl),
    .sdaLvl   (sdaLvl),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .bitCnt   (bitCnt),
    .rxNext   (rxNext),
    .txNextBit(txNextBit),
    .byteIdx  (byteIdx)
  );

  i2c_slave_ctrl #(
    .DEV_PREFIX(DEV_PREFIX),
    .GC_CMD    (GC_CMD),
    .HS_TAG    (HS_TAG)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .strapLsb (strapLsb),
    .sclLvl   (sclLvl),
    .sdaLvl   (sdaLvl),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .bitCnt   (bitCnt),
    .rxNext   (rxNext),
    .txNextBit(txNextBit),
    .strobe   (strobe),
    .sdaOe    (sdaOe),
    .rxFire   (rxValid),
    .hsMode   (hsMode),
    .gcReset  (gcReset)
  );

  assign startEvt = startDet;
  assign stopEvt  = stopDet;
  assign rxByte   = rxNext;
  assign txReq    = strobe.loadTx;

endmodule

// File: tb/sim_i2c_slave_front.sv
module sim_i2c_slave_front;

  localparam int BIDX   = 3;
  localparam int IDXMAX = (1 << BIDX) - 1;
  localparam int Q      = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic strap = 1'b0;
  logic [7:0] patBase = 8'h00;

  logic sdaOe, startEvt, stopEvt, rxValid, txReq, hsMode, gcReset;
  logic [7:0] rxByte;
  logic [7:0] txByte;
  logic [BIDX-1:0] byteIdx;

  wire sdaBus = sdaM & ~sdaOe;

  always #5 clk = ~clk;

  function automatic logic [7:0] wrPat(input logic [7:0] b, input int i);
    return b + 8'(i * 29);
  endfunction

  function automatic logic [7:0] rdPat(input logic [7:0] b, input int i);
    return b ^ 8'(i * 59);
  endfunction

  function automatic int capIdx(input int i);
    return (i > IDXMAX) ? IDXMAX : i;
  endfunction

  assign txByte = rdPat(patBase, int'(byteIdx));

  i2c_slave_front #(.IDX_W(BIDX)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .strapLsb(strap),
    .sdaOe(sdaOe), .startEvt(startEvt), .stopEvt(stopEvt), .rxValid(rxValid),
    .rxByte(rxByte), .txReq(txReq), .txByte(txByte), .byteIdx(byteIdx),
    .hsMode(hsMode), .gcReset(gcReset)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] logB [0:511];
  int logI [0:511];
  int logN = 0, startCnt = 0, stopCnt = 0, gcCnt = 0, txCnt = 0, oeViol = 0;
  logic prevOe = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid) begin
        if (logN < 512) begin
          logB[logN] = rxByte;
          logI[logN] = int'(byteIdx);
        end
        logN++;
      end
      if (startEvt) startCnt++;
      if (stopEvt) stopCnt++;
      if (gcReset) gcCnt++;
      if (txReq) txCnt++;
      if (sdaOe != prevOe && sclM) oeViol++;
      prevOe = sdaOe;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    waitQ(); sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(2);
    sdaM = 1'b0; waitQ(2); sclM = 1'b0;
  endtask

  task automatic busStop();
    waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(2);
    sdaM = 1'b1; waitQ(2);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      waitQ(); sdaM = b[i]; waitQ(); sclM = 1'b1; waitQ(2); sclM = 1'b0;
    end
    waitQ(); sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    ack = ~sdaBus;
    waitQ(); sclM = 1'b0;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      waitQ(); sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
      b[i] = sdaBus;
      waitQ(); sclM = 1'b0;
    end
    waitQ(); sdaM = ~ackIt; waitQ(); sclM = 1'b1; waitQ(2); sclM = 1'b0;
  endtask

  task automatic writeTxn(input logic [6:0] a, input int n, input logic [7:0] base, input bit expAck);
    int l0, s0, p0;
    bit ack;
    l0 = logN; s0 = startCnt; p0 = stopCnt;
    busStart();
    sendByte({a, 1'b0}, ack);
    chk(ack == expAck, expAck ? "R1 addr ack" : "R6 foreign addr nack", ack, expAck);
    for (int i = 0; i < n; i++) begin
      sendByte(wrPat(base, i), ack);
      chk(ack == expAck, expAck ? "R3 data ack" : "R6 data ignored", ack, expAck);
    end
    busStop();
    chk(logN - l0 == (expAck ? n : 0), expAck ? "R4 byte count" : "R6 no delivery",
        logN - l0, expAck ? n : 0);
    if (expAck) begin
      for (int i = 0; i < n; i++) begin
        chk(logB[l0+i] == wrPat(base, i), "R4 byte value", logB[l0+i], wrPat(base, i));
        chk(logI[l0+i] == capIdx(i), "R4 byte index", logI[l0+i], capIdx(i));
      end
    end
    chk(startCnt - s0 == 1, "R2 start count", startCnt - s0, 1);
    chk(stopCnt - p0 == 1, "R2 stop count", stopCnt - p0, 1);
  endtask

  task automatic readTxn(input logic [6:0] a, input int n, input logic [7:0] base);
    int t0;
    bit ack;
    logic [7:0] b;
    patBase = base;
    t0 = txCnt;
    busStart();
    sendByte({a, 1'b1}, ack);
    chk(ack == 1'b1, "R1 read addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b);
      chk(b == rdPat(base, capIdx(i)), "R5 read byte", b, rdPat(base, capIdx(i)));
    end
    busStop();
    chk(txCnt - t0 == n, "R5 fetch count", txCnt - t0, n);
    chk(sdaOe == 1'b0, "R5 released after nack", sdaOe, 0);
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    logic [6:0] dev;
    int l0, t0, s0, g0;
    int unsigned seedInit;
    seedInit = $urandom(32'd771);

    repeat (5) @(negedge clk);
    chk(sdaOe == 1'b0, "R10 reset oe", sdaOe, 0);
    chk(hsMode == 1'b0, "R10 reset hs", hsMode, 0);
    chk(byteIdx == '0, "R10 reset idx", byteIdx, 0);
    rstN = 1'b1;
    waitQ(2);

    // directed: both straps, matching and neighbouring address
    strap = 1'b0;
    writeTxn(7'h74, 3, 8'h5A, 1'b1);
    writeTxn(7'h75, 2, 8'h11, 1'b0);
    strap = 1'b1;
    writeTxn(7'h75, 9, 8'hE1, 1'b1);
    writeTxn(7'h74, 1, 8'h33, 1'b0);
    readTxn(7'h75, 4, 8'hC3);

    // pointer write then repeated START into a read
    dev = 7'h75; patBase = 8'h2D;
    l0 = logN; t0 = txCnt; s0 = startCnt;
    busStart();
    sendByte({dev, 1'b0}, ack);
    sendByte(8'h02, ack);
    chk(ack == 1'b1, "R4 pointer ack", ack, 1);
    busStart();
    sendByte({dev, 1'b1}, ack);
    chk(ack == 1'b1, "R1 read after restart", ack, 1);
    recvByte(1'b1, b);
    chk(b == rdPat(8'h2D, 0), "R5 restart byte0", b, rdPat(8'h2D, 0));
    recvByte(1'b0, b);
    chk(b == rdPat(8'h2D, 1), "R5 restart byte1", b, rdPat(8'h2D, 1));
    busStop();
    chk(logN - l0 == 1, "R4 pointer delivered", logN - l0, 1);
    chk(logB[l0] == 8'h02, "R4 pointer value", logB[l0], 8'h02);
    chk(txCnt - t0 == 2, "R5 restart fetches", txCnt - t0, 2);
    chk(startCnt - s0 == 2, "R2 repeated start seen", startCnt - s0, 2);

    // high-speed master code
    busStart();
    sendByte(8'h08 | 8'($urandom % 8), ack);
    chk(ack == 1'b0, "R7 master code nack", ack, 0);
    chk(hsMode == 1'b1, "R7 flag set", hsMode, 1);
    busStart();
    sendByte({dev, 1'b0}, ack);
    chk(ack == 1'b1, "R1 addr in hs", ack, 1);
    sendByte(8'h11, ack);
    chk(hsMode == 1'b1, "R8 flag kept over restart", hsMode, 1);
    busStop();
    chk(hsMode == 1'b0, "R8 flag cleared by stop", hsMode, 0);

    // general call
    g0 = gcCnt;
    busStart();
    sendByte(8'h00, ack);
    chk(ack == 1'b1, "R9 gc addr ack", ack, 1);
    sendByte(8'h06, ack);
    chk(ack == 1'b1, "R9 gc cmd ack", ack, 1);
    sendByte(8'h06, ack);
    chk(ack == 1'b1, "R9 gc cmd ack again", ack, 1);
    busStop();
    chk(gcCnt - g0 == 2, "R9 gc pulses", gcCnt - g0, 2);
    g0 = gcCnt;
    busStart();
    sendByte(8'h00, ack);
    chk(ack == 1'b1, "R9 gc addr ack", ack, 1);
    sendByte(8'h07, ack);
    chk(ack == 1'b0, "R9 other gc data nack", ack, 0);
    busStop();
    chk(gcCnt == g0, "R9 no pulse", gcCnt - g0, 0);

    // constrained random transfers
    for (int it = 0; it < 14; it++) begin
      int kind, n;
      logic [7:0] base;
      strap = 1'($urandom % 2);
      dev = {6'b111010, strap};
      kind = int'($urandom % 3);
      n = 1 + int'($urandom % 5);
      base = 8'($urandom);
      if (kind == 0) writeTxn(dev, n, base, 1'b1);
      else if (kind == 1) readTxn(dev, n, base);
      else writeTxn(7'(8 + $urandom % 108), n, base, 1'b0);
    end

    chk(oeViol == 0, "R3 oe moved with SCL high", oeViol, 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule